// File: doc/BRIEF.md
# Downcounting Watchdog Reset Timer

This peripheral guards a microcontroller against runaway software. A 7-bit counter sits in the low bits of an 8-bit control register and counts down by one every `DIV` clocks while the watchdog is running. Software must rewrite the control register before bit 6 of the counter drops from 1 to 0. If it does not, the block raises a one-cycle reset request for the external reset generator. A request is also raised when software writes the control register with bit 6 clear while the watchdog is enabled. A halt indication from the CPU while the watchdog is running raises one as well. A status register keeps a flag that records that the last reset came from the watchdog.

The enable bit (control bit 7) is a one-way latch: software can set it, and only a reset clears it. A static strap input keeps the watchdog running whatever the enable bit holds. The reset generator drives back two inputs. `por_n` is the asynchronous power-on reset and clears everything. `wdg_rst_i` is a synchronous watchdog-caused reset: it sets the flag, reloads the control register to 7Fh and clears the enable latch.

The control sequence is a four-state machine. OFF means not running. ARMED means running. FIRE is the cycle in which the request pulse is output. HOLD means waiting for the reset to come back. The transitions are:
- OFF→ARMED when the enable latch is set or the strap is high.
- OFF→FIRE and ARMED→FIRE on any reset cause.
- ARMED→OFF if the block is no longer running.
- FIRE→HOLD always, after one cycle.
- HOLD→OFF, and any state→OFF, on `wdg_rst_i`.

Top module: `wdog_core`

## Requirements
- R1: After power-on reset the control register (address 0) reads 7Fh, the status register (address 1) reads 00h and `rst_req_o` is low.
- R2: Writing control bit 7 as 1 sets the enable latch. Writing it as 0 leaves the latch unchanged. Only `wdg_rst_i` or `por_n` clears the latch.
- R3: While running, the counter (control bits 6..0) decreases by one every `DIV` clocks. Each control write restarts the prescaler, so the first decrement after a write happens at the `DIV`-th rising edge after the write edge.
- R4: While not running (enable latch clear and strap low), the counter holds the value last written.
- R5: While running, the decrement from 40h to 3Fh raises `rst_req_o` in the cycle right after that edge.
- R6: A control write with bit 6 = 0 raises `rst_req_o` in the next cycle if the block is enabled after the write. Enabled here means the latch was already set, written bit 7 = 1, or the strap is high. The same write with the block left disabled only loads the counter.
- R7: `halt_i` high while running raises `rst_req_o` in the next cycle. `halt_i` has no effect while the block is not running.
- R8: With `hw_strap_i` high the block runs and issues requests even when the enable latch is clear.
- R9: `rst_req_o` is high for exactly one cycle. After that the block is in HOLD until `wdg_rst_i`. In HOLD, further reset causes are ignored, control writes are ignored and the counter is frozen.
- R10: `wdg_rst_i` sets status bit 0, reloads the control register to 7Fh and clears the enable latch.
- R11: Writing status bit 0 as 0 clears the flag. Writing it as 1 does not set it. Status bits 7..1 always read 0.
- R12: If a control write and a prescaler tick fall on the same edge, the write wins and no timeout request comes from that tick. Several reset causes on the same edge give one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wdg_rst_i | input | 1 | Synchronous watchdog-caused reset from the reset generator |
| hw_strap_i | input | 1 | Static strap that forces the watchdog to run |
| halt_i | input | 1 | CPU halt indication |
| bus_addr_i | input | 1 | Register select: 0 = control, 1 = status |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register (combinational) |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Two pairs of events can land on the same edge. The first pair is a control-register reload and the prescaler tick that would have carried the counter from 40h to 3Fh. The second pair is a halt indication and that same timeout tick. The bench loads C0h, waits exactly `DIV-1` falling edges and then reloads C0h, so the reload arrives on the tick edge. It then checks that no request follows. Next it raises `halt_i` on the tick edge of the following period and counts exactly one request pulse. A behavioural model compares the request line and the read data on every clock, so any pulse that is late, doubled or missing is reported in the cycle where it happens.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2,
        WD_HOLD  = 2'd3
    } wd_state_e;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    localparam int        CNT_W     = 7;
    localparam logic [CNT_W-1:0] CNT_RELOAD = 7'h7F;
    localparam logic [CNT_W-1:0] CNT_EDGE   = 7'h40;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV = 12288
) (
    input  logic clk,
    input  logic por_n,
    input  logic wdg_rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] pre_q;

    assign tick = run && (pre_q == LAST);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre_q <= '0;
        end else if (wdg_rst || restart || !run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_restart_chk
            // R3
            restart_no_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
                restart |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wdg_rst,
    input  logic             ctrl_we,
    input  logic             stat_we,
    input  logic [7:0]       wdata,
    input  logic             tick,
    input  logic             sel,
    output logic             act_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             flag_q,
    output logic [7:0]       rdata
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            act_q <= 1'b0;
            cnt_q <= CNT_RELOAD;
        end else if (wdg_rst) begin
            act_q <= 1'b0;
            cnt_q <= CNT_RELOAD;
        end else if (ctrl_we) begin
            act_q <= act_q | wdata[7];
            cnt_q <= wdata[CNT_W-1:0];
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (wdg_rst) begin
            flag_q <= 1'b1;
        end else if (stat_we) begin
            flag_q <= flag_q & wdata[0];
        end
    end

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_CTRL: rdata = {act_q, cnt_q};
            SEL_STAT: rdata = {7'b0, flag_q};
            default:  rdata = 8'h00;
        endcase
    end

    // R2
    act_latch_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(act_q) |-> $past(wdg_rst));

    // R11
    flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flag_q) |-> $past(wdg_rst));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(cnt_q) |-> $past(ctrl_we || tick || wdg_rst));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wdg_rst,
    input  logic             active,
    input  logic             ctrl_we,
    input  logic [1:0]       wtop,
    input  logic             act_q,
    input  logic             strap,
    input  logic             halt,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    output logic             pending,
    output logic             rst_req
);
    wd_state_e state_q, state_d;
    logic sw_fire, halt_fire, to_fire, fire;

    always_comb begin
        sw_fire   = ctrl_we && (act_q || wtop[1] || strap) && !wtop[0];
        halt_fire = halt && active;
        to_fire   = tick && (cnt == CNT_EDGE) && !ctrl_we;
        fire      = sw_fire || halt_fire || to_fire;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:   state_d = fire ? WD_FIRE : (active ? WD_ARMED : WD_OFF);
            WD_ARMED: state_d = fire ? WD_FIRE : (active ? WD_ARMED : WD_OFF);
            WD_FIRE:  state_d = WD_HOLD;
            WD_HOLD:  state_d = WD_HOLD;
            default:  state_d = WD_OFF;
        endcase
        if (wdg_rst) state_d = WD_OFF;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        rst_req = (state_q == WD_FIRE);
        pending = (state_q == WD_FIRE) || (state_q == WD_HOLD);
    end

    // R9
    pulse_one_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // R9
    hold_stay_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == WD_HOLD && !wdg_rst) |=> (state_q == WD_HOLD));

    // R7
    halt_fire_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == WD_ARMED && halt && !wdg_rst) |=> rst_req);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int DIV = 12288
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wdg_rst_i,
    input  logic       hw_strap_i,
    input  logic       halt_i,
    input  logic       bus_addr_i,
    input  logic       bus_we_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       rst_req_o
);
    logic             act_q, flag_q, pending, active, run, tick;
    logic             ctrl_we, stat_we;
    logic [CNT_W-1:0] cnt_q;

    assign active  = act_q | hw_strap_i;
    assign run     = active && !pending;
    assign ctrl_we = bus_we_i && (bus_addr_i == SEL_CTRL) && !pending;
    assign stat_we = bus_we_i && (bus_addr_i == SEL_STAT);

    wdog_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .por_n   (por_n),
        .wdg_rst (wdg_rst_i),
        .run     (run),
        .restart (ctrl_we),
        .tick    (tick)
    );

    wdog_regs u_regs (
        .clk     (clk),
        .por_n   (por_n),
        .wdg_rst (wdg_rst_i),
        .ctrl_we (ctrl_we),
        .stat_we (stat_we),
        .wdata   (bus_wdata_i),
        .tick    (tick),
        .sel     (bus_addr_i),
        .act_q   (act_q),
        .cnt_q   (cnt_q),
        .flag_q  (flag_q),
        .rdata   (bus_rdata_o)
    );

    wdog_fsm u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .wdg_rst (wdg_rst_i),
        .active  (active),
        .ctrl_we (ctrl_we),
        .wtop    (bus_wdata_i[7:6]),
        .act_q   (act_q),
        .strap   (hw_strap_i),
        .halt    (halt_i),
        .tick    (tick),
        .cnt     (cnt_q),
        .pending (pending),
        .rst_req (rst_req_o)
    );

    // R10
    wrst_reload_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdg_rst_i |=> (cnt_q == CNT_RELOAD && !act_q && flag_q && !rst_req_o));

endmodule

// File: tb/wdog_core_test.sv
`timescale 1ns/1ps
module wdog_core_test;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wdg_rst = 1'b0, strap = 1'b0, halt = 1'b0;
    logic       bus_addr = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rst_req;

    int checks = 0, fails = 0;
    bit done = 0;
    string phase = "R1";

    wdog_core #(.DIV(DIV)) uut (
        .clk(clk), .por_n(por_n), .wdg_rst_i(wdg_rst), .hw_strap_i(strap),
        .halt_i(halt), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .rst_req_o(rst_req)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    logic       m_act, m_flag;
    logic [6:0] m_t;
    int         m_pre, m_st;  // m_st: 0 running/idle, 2 pulse, 3 waiting

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_act = 0; m_t = 7'h7F; m_pre = 0; m_flag = 0; m_st = 0;
        end else if (wdg_rst) begin
            m_act = 0; m_t = 7'h7F; m_pre = 0; m_flag = 1; m_st = 0;
        end else begin
            bit pend, act_now, run_now, crw, tk, fire;
            pend    = (m_st >= 2);
            act_now = m_act || strap;
            run_now = act_now && !pend;
            crw     = bus_we && !bus_addr && !pend;
            tk      = run_now && (m_pre == DIV - 1);
            fire    = !pend && ((crw && (m_act || bus_wdata[7] || strap) && !bus_wdata[6])
                               || (halt && act_now)
                               || (tk && m_t == 7'h40 && !crw));
            if (crw || !run_now || tk) m_pre = 0; else m_pre = m_pre + 1;
            if (crw) begin
                m_t = bus_wdata[6:0];
                m_act = m_act || bus_wdata[7];
            end else if (tk) m_t = m_t - 7'd1;
            if (bus_we && bus_addr) m_flag = m_flag & bus_wdata[0];
            if (m_st == 2 || m_st == 3) m_st = 3;
            else if (fire) m_st = 2;
            else m_st = 0;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (por_n && !done) begin
            check({phase, " per-cycle rst_req"}, {7'b0, rst_req}, {7'b0, (m_st == 2) ? 1'b1 : 1'b0});
            check({phase, " per-cycle rdata"}, bus_rdata,
                  bus_addr ? {7'b0, m_flag} : {m_act, m_t});
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wrst();
        wdg_rst = 1'b1; @(posedge clk); @(negedge clk); wdg_rst = 1'b0;
    endtask

    task automatic watch(input int n, output int pulses);
        pulses = 0;
        repeat (n) begin @(negedge clk); #1; if (rst_req) pulses++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int p;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1
        phase = "R1";
        rd(0, d); check("R1 ctrl reset", d, 8'h7F);
        rd(1, d); check("R1 stat reset", d, 8'h00);
        check("R1 rst_req reset", {7'b0, rst_req}, 8'h00);

        // R4: inactive counter holds, disabled write with bit6=0 only loads
        phase = "R4";
        wr(0, 8'h55); repeat (40) @(negedge clk);
        rd(0, d); check("R4 hold 55", d, 8'h55);
        phase = "R6";
        wr(0, 8'h20); #1; check("R6 disabled sw write no pulse", {7'b0, rst_req}, 8'h00);
        rd(0, d); check("R6 disabled load", d, 8'h20);

        // R3 / R2 / R5 / R9
        phase = "R3";
        wr(0, 8'hC5); repeat (2 * DIV) @(negedge clk);
        rd(0, d); check("R3 two decrements", d, 8'hC3);
        phase = "R2";
        wr(0, 8'h45); rd(0, d); check("R2 enable kept", d, 8'hC5);
        phase = "R5";
        watch(6 * DIV + 10, p); check("R5 single timeout pulse", 8'(p), 8'd1);
        phase = "R9";
        rd(0, d); check("R9 frozen after fire", d, 8'hBF);
        wr(0, 8'hFF); rd(0, d); check("R9 write ignored in hold", d, 8'hBF);
        watch(3 * DIV, p); check("R9 no further pulse", 8'(p), 8'd0);
        // R10 / R11
        phase = "R10";
        wrst(); rd(0, d); check("R10 ctrl reload", d, 8'h7F);
        rd(1, d); check("R10 flag set", d, 8'h01);
        phase = "R11";
        wr(1, 8'hFF); rd(1, d); check("R11 write one keeps", d, 8'h01);
        wr(1, 8'hFE); rd(1, d); check("R11 write zero clears", d, 8'h00);
        wr(1, 8'hFF); rd(1, d); check("R11 write one no set", d, 8'h00);

        // R6: software reset
        phase = "R6";
        wr(0, 8'h80); #1; check("R6 sw reset pulse", {7'b0, rst_req}, 8'h01);
        wrst();

        // R7: halt
        phase = "R7";
        halt = 1'b1; watch(5, p); halt = 1'b0;
        check("R7 halt ignored inactive", 8'(p), 8'd0);
        rd(0, d); check("R7 ctrl unchanged", d, 8'h7F);
        wr(0, 8'hFF); halt = 1'b1; watch(5, p); halt = 1'b0;
        check("R7 halt pulse", 8'(p), 8'd1);
        wrst();

        // R8: strap
        phase = "R8";
        strap = 1'b1;
        wr(0, 8'h48); watch(9 * DIV + 8, p); check("R8 strap timeout", 8'(p), 8'd1);
        rd(0, d); check("R8 latch still clear", d, 8'h3F);
        wrst();
        wr(0, 8'h10); #1; check("R8 strap sw reset", {7'b0, rst_req}, 8'h01);
        wrst(); strap = 1'b0;

        // R12: same-edge cases
        phase = "R12";
        wr(0, 8'hC0); repeat (DIV - 1) @(negedge clk);
        wr(0, 8'hC0); #1; check("R12 reload beats tick", {7'b0, rst_req}, 8'h00);
        repeat (DIV - 1) @(negedge clk);
        halt = 1'b1; watch(4, p); halt = 1'b0;
        check("R12 halt plus timeout one pulse", 8'(p), 8'd1);
        wrst();
        repeat (4) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule